// File: doc/BRIEF.md
# Eight-bit GPIO port register block

This block holds the state of one general-purpose I/O port behind a small memory-mapped data bus. There are three registers at consecutive addresses starting at a parameter base: an input view, a direction register and an output latch. Each pin's output enable follows its direction bit, and its drive level follows its output latch bit.

Software reaches the block through an address, write data, a write strobe and a per-bit write mask. Byte stores use a full mask. A single-bit set or clear instruction reads the register, modifies it, and writes it back with a one-hot mask.

A write to the input-view address does not store anything. It inverts the output latch bits selected by both the data and the mask. Because of the mask, a single-bit instruction aimed at the input view inverts exactly one output, even though its read-modify-write data carries other ones. Whenever the direction or output latch changes, a one-cycle change strobe reports the output latch value after the write and before it.

Top module: `io_port_regs`

## Requirements
- R1: After reset the direction register, the output latch, `pad_oe`, `pad_out` and `chg_valid` are all zero.
- R2: A write to address BASE+0 (input view) replaces the output latch with `latch ^ (wdata & wmask)` on the next clock edge, leaving the direction register unchanged.
- R3: With direction = 0x48 and latch = 0x48, a write to BASE+0 carrying data 0x48 and mask 0x40 leaves the latch at 0x08; bit 3 is not inverted.
- R4: A write to BASE+1 (direction) or BASE+2 (output latch) stores `wdata` in the bits where `wmask` is 1 and keeps the other bits unchanged.
- R5: Writes to any address other than BASE+0..BASE+2 change no state, and reads of those addresses return 0.
- R6: The clock edge that changes the direction register or the output latch also sets `chg_valid` high for exactly one cycle, with `chg_new` = latch after the write and `chg_old` = latch before it. A write that changes neither register raises no strobe.
- R7: A read of BASE+0 returns, per bit, the latch bit where the direction bit is 1. Where the direction bit is 0, it returns the external pin level sampled through a two-flop synchronizer. A level held on `pin_in` shows up after two rising edges.
- R8: `pad_oe` equals the direction register and `pad_out` equals the output latch at all times.
- R9: `bus_rdata` is combinational from `bus_addr` and the current register state. Reads of BASE+1 and BASE+2 return the direction register and the latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (16) | Data-bus address |
| bus_wdata | input | WIDTH (8) | Write data |
| bus_wen | input | 1 | Write strobe |
| bus_wmask | input | WIDTH (8) | Per-bit write mask |
| bus_rdata | output | WIDTH (8) | Read data for `bus_addr` |
| pin_in | input | WIDTH (8) | External pin levels (asynchronous) |
| pad_out | output | WIDTH (8) | Per-pin drive value |
| pad_oe | output | WIDTH (8) | Per-pin output enable |
| chg_valid | output | 1 | One-cycle output change strobe |
| chg_new | output | WIDTH (8) | Latch value after the change |
| chg_old | output | WIDTH (8) | Latch value before the change |

## Verification
The hardest case is a masked toggle whose write data has ones outside the mask, because only a read-modify-write of the input view produces it. The stimulus builds it in two ways. It replays the single-bit sequence directly, and it draws random data paired with one-hot or random masks so that unmasked ones are common. The bench also holds random pin levels for the synchronizer delay before each input-view read, so that mixed direction patterns are checked against both sources.

// File: rtl/io_port_pkg.sv
package io_port_pkg;

    // Register offsets from the base address; the order is part of the map.
    localparam int unsigned OFS_VIEW = 0;
    localparam int unsigned OFS_DIR  = 1;
    localparam int unsigned OFS_OUT  = 2;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_VIEW = 2'd1,
        SEL_DIR  = 2'd2,
        SEL_OUT  = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/io_port_decode.sv
module io_port_decode
    import io_port_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter logic [ADDR_W-1:0] BASE = 16'h0023
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);
    logic [ADDR_W-1:0] offset;

    always_comb begin
        offset = addr - BASE;
        if (offset == ADDR_W'(OFS_VIEW))      sel = SEL_VIEW;
        else if (offset == ADDR_W'(OFS_DIR))  sel = SEL_DIR;
        else if (offset == ADDR_W'(OFS_OUT))  sel = SEL_OUT;
        else                                  sel = SEL_NONE;
    end
endmodule

// File: rtl/io_port_sync.sv
module io_port_sync #(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    localparam int unsigned LAST = STAGES - 1;

    logic [WIDTH-1:0] stg_d [STAGES];
    logic [WIDTH-1:0] stg_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_comb stg_d[s] = async_in;
            end else begin : g_next
                always_comb stg_d[s] = stg_q[s-1];
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[s] <= '0;
                else        stg_q[s] <= stg_d[s];
            end
        end
    endgenerate

    assign sync_out = stg_q[LAST];
endmodule

// File: rtl/io_port_core.sv
module io_port_core
    import io_port_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  reg_sel_e         sel,
    input  logic             wen,
    input  logic [WIDTH-1:0] wdata,
    input  logic [WIDTH-1:0] wmask,
    output logic [WIDTH-1:0] dir_q,
    output logic [WIDTH-1:0] out_q,
    output logic             chg_valid,
    output logic [WIDTH-1:0] chg_new,
    output logic [WIDTH-1:0] chg_old
);
    typedef struct packed {
        logic [WIDTH-1:0] dir;
        logic [WIDTH-1:0] out;
        logic             chg;
        logic [WIDTH-1:0] chg_new;
        logic [WIDTH-1:0] chg_old;
    } core_state_t;

    core_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.chg = 1'b0;
        if (wen) begin
            unique case (sel)
                SEL_VIEW: st_d.out = st_q.out ^ (wdata & wmask);
                SEL_DIR:  st_d.dir = (st_q.dir & ~wmask) | (wdata & wmask);
                SEL_OUT:  st_d.out = (st_q.out & ~wmask) | (wdata & wmask);
                default:  ;
            endcase
        end
        if ((st_d.out != st_q.out) || (st_d.dir != st_q.dir)) begin
            st_d.chg     = 1'b1;
            st_d.chg_new = st_d.out;
            st_d.chg_old = st_q.out;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dir_q     = st_q.dir;
    assign out_q     = st_q.out;
    assign chg_valid = st_q.chg;
    assign chg_new   = st_q.chg_new;
    assign chg_old   = st_q.chg_old;

    p_view_toggle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wen && sel == SEL_VIEW) |=>
            (out_q == ($past(out_q) ^ ($past(wdata) & $past(wmask)))) && $stable(dir_q));

    p_masked_store_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wen && sel == SEL_DIR) |=>
            ((dir_q ^ $past(dir_q)) & ~$past(wmask)) == '0);

    p_no_stray_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!wen || sel == SEL_NONE) |=> ($stable(out_q) && $stable(dir_q)));

    p_change_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(out_q) || !$stable(dir_q)) |-> chg_valid);

    p_strobe_values_r6: assert property (@(posedge clk) disable iff (!rst_n)
        chg_valid |-> (chg_new == out_q && chg_old == $past(out_q)));
endmodule

// File: rtl/io_port_regs.sv
module io_port_regs
    import io_port_pkg::*;
#(
    parameter int unsigned       WIDTH  = 8,
    parameter int unsigned       ADDR_W = 16,
    parameter logic [ADDR_W-1:0] BASE   = 16'h0023,
    parameter int unsigned       SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WIDTH-1:0]  bus_wdata,
    input  logic              bus_wen,
    input  logic [WIDTH-1:0]  bus_wmask,
    output logic [WIDTH-1:0]  bus_rdata,
    input  logic [WIDTH-1:0]  pin_in,
    output logic [WIDTH-1:0]  pad_out,
    output logic [WIDTH-1:0]  pad_oe,
    output logic              chg_valid,
    output logic [WIDTH-1:0]  chg_new,
    output logic [WIDTH-1:0]  chg_old
);
    reg_sel_e         sel;
    logic [WIDTH-1:0] dir_q;
    logic [WIDTH-1:0] out_q;
    logic [WIDTH-1:0] pin_sync;
    logic [WIDTH-1:0] view_val;

    io_port_decode #(.ADDR_W(ADDR_W), .BASE(BASE)) u_decode (
        .addr (bus_addr),
        .sel  (sel)
    );

    io_port_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (pin_sync)
    );

    io_port_core #(.WIDTH(WIDTH)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel       (sel),
        .wen       (bus_wen),
        .wdata     (bus_wdata),
        .wmask     (bus_wmask),
        .dir_q     (dir_q),
        .out_q     (out_q),
        .chg_valid (chg_valid),
        .chg_new   (chg_new),
        .chg_old   (chg_old)
    );

    always_comb begin
        view_val = (out_q & dir_q) | (pin_sync & ~dir_q);
        unique case (sel)
            SEL_VIEW: bus_rdata = view_val;
            SEL_DIR:  bus_rdata = dir_q;
            SEL_OUT:  bus_rdata = out_q;
            default:  bus_rdata = '0;
        endcase
    end

    assign pad_out = out_q;
    assign pad_oe  = dir_q;

    p_view_outputs_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_VIEW) |-> (((bus_rdata ^ pad_out) & pad_oe) == '0));

    p_sync_delay_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_VIEW && $stable(pin_in) && $stable(pad_oe)) |->
            (((bus_rdata ^ $past(pin_in, 2)) & ~pad_oe) == '0) || !$stable($past(pin_in)));
endmodule

// File: tb/tb_io_port_regs.sv
module tb_io_port_regs;
    localparam int unsigned W    = 8;
    localparam int unsigned AW   = 16;
    localparam logic [15:0] BASE = 16'h0029;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [W-1:0]  bus_wdata = '0;
    logic          bus_wen = 1'b0;
    logic [W-1:0]  bus_wmask = '0;
    logic [W-1:0]  bus_rdata;
    logic [W-1:0]  pin_in = '0;
    logic [W-1:0]  pad_out, pad_oe, chg_new, chg_old;
    logic          chg_valid;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic [W-1:0] m_dir = '0;
    logic [W-1:0] m_out = '0;

    always #2.5 clk = ~clk;

    io_port_regs #(.WIDTH(W), .ADDR_W(AW), .BASE(BASE)) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wen(bus_wen), .bus_wmask(bus_wmask), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .chg_valid(chg_valid), .chg_new(chg_new), .chg_old(chg_old)
    );

    function automatic logic [W-1:0] f_view(logic [W-1:0] d, logic [W-1:0] o, logic [W-1:0] p);
        return (o & d) | (p & ~d);
    endfunction

    function automatic logic [W-1:0] f_store(logic [W-1:0] cur, logic [W-1:0] v, logic [W-1:0] m);
        return (cur & ~m) | (v & m);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic read_chk(string req, logic [AW-1:0] a, logic [W-1:0] exp);
        bus_addr = a;
        #1;
        chk(req, 32'(bus_rdata), 32'(exp));
    endtask

    task automatic do_write(logic [AW-1:0] a, logic [W-1:0] d, logic [W-1:0] m);
        logic [W-1:0] nd, no;
        logic         ch;
        nd = m_dir;
        no = m_out;
        if (a == BASE)           no = m_out ^ (d & m);
        else if (a == BASE + 1)  nd = f_store(m_dir, d, m);
        else if (a == BASE + 2)  no = f_store(m_out, d, m);
        ch = (nd != m_dir) || (no != m_out);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wmask = m; bus_wen = 1'b1;
        @(negedge clk);
        bus_wen = 1'b0;
        chk("R6 strobe", 32'(chg_valid), 32'(ch));
        if (ch) begin
            chk("R6 new", 32'(chg_new), 32'(no));
            chk("R6 old", 32'(chg_old), 32'(m_out));
        end
        m_dir = nd;
        m_out = no;
        chk("R8 pad_out", 32'(pad_out), 32'(m_out));
        chk("R8 pad_oe", 32'(pad_oe), 32'(m_dir));
        @(negedge clk);
        chk("R6 one cycle", 32'(chg_valid), 32'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog act=running exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] pins;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk("R1 pad_out", 32'(pad_out), 32'h0);
        chk("R1 pad_oe", 32'(pad_oe), 32'h0);
        chk("R1 chg", 32'(chg_valid), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        read_chk("R1 dir", BASE + 1, 8'h00);
        read_chk("R1 out", BASE + 2, 8'h00);

        // R3: direction and latch 0x48, then single-bit set on input view
        do_write(BASE + 1, 8'h48, 8'hFF);
        do_write(BASE + 2, 8'h48, 8'hFF);
        read_chk("R9 dir read", BASE + 1, 8'h48);
        read_chk("R7 view read", BASE, 8'h48);
        do_write(BASE, 8'h48 | 8'h40, 8'h40);
        read_chk("R3 latch 0x08", BASE + 2, 8'h08);
        chk("R3 pad_out", 32'(pad_out), 32'h08);

        // R2: full-mask toggle of input view, pins with dir 0 included
        do_write(BASE, 8'hFF, 8'hFF);
        read_chk("R2 full toggle", BASE + 2, 8'hF7);
        read_chk("R2 dir kept", BASE + 1, 8'h48);

        // R4: masked store
        do_write(BASE + 2, 8'h00, 8'h0F);
        read_chk("R4 masked store", BASE + 2, 8'hF0);

        // R6: write with no effect gives no strobe
        do_write(BASE + 2, 8'hF0, 8'hFF);
        do_write(BASE, 8'hFF, 8'h00);

        // R5: unmapped writes and reads
        do_write(BASE + 3, 8'hAA, 8'hFF);
        do_write(BASE - 1, 8'h55, 8'hFF);
        read_chk("R5 unmapped +3", BASE + 3, 8'h00);
        read_chk("R5 unmapped -1", BASE - 1, 8'h00);
        read_chk("R5 latch kept", BASE + 2, m_out);

        // R7: synchronizer delay, inputs on dir-0 bits
        @(negedge clk);
        pin_in = 8'hA5;
        bus_addr = BASE;
        @(negedge clk);
        chk("R7 one edge stale", 32'(bus_rdata & ~m_dir), 32'h0);
        @(negedge clk);
        read_chk("R7 two edges", BASE, f_view(m_dir, m_out, 8'hA5));

        // Random phase
        for (int i = 0; i < 300; i++) begin
            logic [AW-1:0] a;
            logic [W-1:0]  d, m;
            int unsigned   r;
            pins = W'($urandom);
            @(negedge clk);
            pin_in = pins;
            repeat (2) @(negedge clk);
            read_chk("R7 random view", BASE, f_view(m_dir, m_out, pins));
            r = $urandom % 5;
            a = (r < 3) ? BASE + AW'(r) : ((r == 3) ? BASE + 3 : AW'(16'h0080 + ($urandom % 64)));
            d = W'($urandom);
            r = $urandom % 3;
            m = (r == 0) ? 8'hFF : ((r == 1) ? W'(8'h01 << ($urandom % W)) : W'($urandom));
            do_write(a, d, m);
            read_chk("R9 random dir", BASE + 1, m_dir);
            read_chk("R4 random latch", BASE + 2, m_out);
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule